// File: doc/BRIEF.md
# Sample Averaging Accumulator

This block sits between the result stream of a 12-bit converter and a result FIFO. It adds up a power-of-two number of consecutive converter samples and forwards their mean as a single FIFO entry. Averaging trades throughput for precision: a group of N samples yields exactly one output entry. One averager serves every input channel, so all channels get the same factor whatever their input type.

A 3-bit control field gives the log2 of the group size. A value of 0 means bypass, where every sample passes through unchanged. Values above 6 act as 6, which is 64 samples. The control value is captured when the first sample of a group is accepted and holds until that group completes. Each sample carries a channel/step tag and an interrupt-enable flag. The entry written for a group carries the tag and flag of its last sample. When an entry whose flag is set leaves the block, the interrupt output pulses once.

Both data sides are valid/ready streams. An input sample is taken when `in_valid` and `in_ready` are both high. An output entry is taken when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the entry and its tag and flag stay unchanged and `in_ready` is low. `in_ready` is high whenever the output holds nothing or is being drained in the same cycle. The control field and the interrupt are plain pins.

Top module: `avg_accum`

## Requirements
- R1: During and just after reset, `out_valid` and `irq` are 0 and the averaging control value is whatever the `avg_ctl` pin holds. With 0 on that pin the block is in bypass.
- R2: With `avg_ctl` = 0, each accepted sample appears as an output entry with the same data, tag and flag. It is presented on `out_valid` in the cycle after acceptance.
- R3: With `avg_ctl` = k in 1..6, every 2^k accepted samples produce exactly one entry. Its value is floor(sum / 2^k), truncated with no rounding. No entry appears before the group's last sample is accepted.
- R4: Any `avg_ctl` value of 7 behaves exactly like 6: 64-sample groups divided by 64.
- R5: `avg_ctl` is sampled only when the first sample of a group is accepted. A change during a group has no effect on that group and applies from the next group onward.
- R6: The tag and interrupt-enable flag of an entry are those of the last sample of its group.
- R7: A group of 64 full-scale samples (4095 each) yields 4095, so the 18-bit sum never overflows.
- R8: When `out_valid` is high and `out_ready` is low, the entry, tag and flag are held on the next cycle and `in_ready` is low. `in_ready` equals (not `out_valid`) or `out_ready`.
- R9: `irq` is high for exactly one cycle, in the cycle after an entry whose flag is 1 is handshaked. It is never high at any other time.
- R10: Samples are combined by arrival order only, so samples with different tags in one group are averaged together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| avg_ctl | input | 3 | log2 of group size; 0 = bypass, 7 acts as 6 |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 12 | Converter sample |
| in_tag | input | 4 | Channel / sequence-step tag of the sample |
| in_ie | input | 1 | Interrupt-enable flag of the sample |
| out_valid | output | 1 | Averaged entry present |
| out_ready | input | 1 | FIFO can take the entry |
| out_data | output | 12 | Averaged value |
| out_tag | output | 4 | Tag of the group's last sample |
| out_ie | output | 1 | Flag of the group's last sample |
| irq | output | 1 | One-cycle pulse after a flagged entry is taken |

## Verification
The bench changes `avg_ctl` in the middle of a group. A design that sampled the pin on every sample would close the group early or divide by the wrong shift. It drives 64 full-scale samples with control value 7. A design that did not clamp, or whose sum was too narrow, would wait for 128 samples or wrap to a small value. It holds `out_ready` low while a new sample waits at the input, and puts the interrupt flag on the first sample of a group rather than the last. A design that dropped back-pressure, overwrote a held entry, or took the tag from the wrong sample would show a changed entry or a wrong or missing `irq` pulse.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int unsigned AVG_DATA_W   = 12;
  localparam int unsigned AVG_TAG_W    = 4;
  localparam int unsigned AVG_CTL_W    = 3;
  localparam int unsigned AVG_MAX_LOG2 = 6;
endpackage

// File: rtl/avg_ctl_clamp.sv
module avg_ctl_clamp #(
  parameter int unsigned CTL_W    = 3,
  parameter int unsigned MAX_LOG2 = 6
) (
  input  logic [CTL_W-1:0] ctl_raw,
  output logic [CTL_W-1:0] ctl_eff
);
  localparam int unsigned CTL_TOP = (1 << CTL_W) - 1;

  generate
    if (MAX_LOG2 >= CTL_TOP) begin : g_no_clamp
      assign ctl_eff = ctl_raw;
    end else begin : g_clamp
      localparam logic [CTL_W-1:0] LIMIT = CTL_W'(MAX_LOG2);
      assign ctl_eff = (ctl_raw > LIMIT) ? LIMIT : ctl_raw;
    end
  endgenerate
endmodule

// File: rtl/avg_accum_core.sv
module avg_accum_core #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned CTL_W    = 3,
  parameter int unsigned MAX_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_eff,
  input  logic              take,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [TAG_W-1:0]  smp_tag,
  input  logic              smp_ie,
  output logic              grp_done,
  output logic [DATA_W-1:0] grp_mean,
  output logic [TAG_W-1:0]  grp_tag,
  output logic              grp_ie,
  output logic              grp_idle
);
  localparam int unsigned ACC_W = DATA_W + MAX_LOG2;
  localparam int unsigned CNT_W = MAX_LOG2 + 1;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CTL_W-1:0] log2_q;

  logic [CTL_W-1:0] cur_log2;
  logic [ACC_W-1:0] acc_base;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] acc_shift;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] grp_size;

  always_comb begin
    grp_idle  = (cnt_q == '0);
    cur_log2  = grp_idle ? ctl_eff : log2_q;
    acc_base  = grp_idle ? '0 : acc_q;
    acc_sum   = acc_base + ACC_W'(smp_data);
    acc_shift = acc_sum >> cur_log2;
    cnt_inc   = cnt_q + CNT_W'(1);
    grp_size  = CNT_W'(1) << cur_log2;
    grp_done  = take && (cnt_inc == grp_size);
    grp_mean  = acc_shift[DATA_W-1:0];
    grp_tag   = smp_tag;
    grp_ie    = smp_ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      log2_q <= '0;
    end else if (take) begin
      log2_q <= cur_log2;
      if (grp_done) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_sum;
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/avg_out_stage.sv
module avg_out_stage #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              ld_ie,
  input  logic              out_ready,
  output logic              space,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_ie,
  output logic              irq
);
  logic drain;

  assign drain = out_valid && out_ready;
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
      out_ie    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= drain && out_ie;
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= ld_data;
        out_tag   <= ld_tag;
        out_ie    <= ld_ie;
      end else if (drain) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/avg_accum.sv
module avg_accum
  import avg_pkg::*;
#(
  parameter int unsigned DATA_W   = AVG_DATA_W,
  parameter int unsigned TAG_W    = AVG_TAG_W,
  parameter int unsigned CTL_W    = AVG_CTL_W,
  parameter int unsigned MAX_LOG2 = AVG_MAX_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  avg_ctl,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_ie,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_ie,
  output logic              irq
);
  logic [CTL_W-1:0]  ctl_eff;
  logic              take;
  logic              grp_done;
  logic [DATA_W-1:0] grp_mean;
  logic [TAG_W-1:0]  grp_tag;
  logic              grp_ie;
  logic              grp_idle;
  logic              space;

  assign in_ready = space;
  assign take     = in_valid && space;

  avg_ctl_clamp #(.CTL_W(CTL_W), .MAX_LOG2(MAX_LOG2)) u_clamp (
    .ctl_raw (avg_ctl),
    .ctl_eff (ctl_eff)
  );

  avg_accum_core #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .CTL_W(CTL_W), .MAX_LOG2(MAX_LOG2)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_eff  (ctl_eff),
    .take     (take),
    .smp_data (in_data),
    .smp_tag  (in_tag),
    .smp_ie   (in_ie),
    .grp_done (grp_done),
    .grp_mean (grp_mean),
    .grp_tag  (grp_tag),
    .grp_ie   (grp_ie),
    .grp_idle (grp_idle)
  );

  avg_out_stage #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (grp_done),
    .ld_data   (grp_mean),
    .ld_tag    (grp_tag),
    .ld_ie     (grp_ie),
    .out_ready (out_ready),
    .space     (space),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag),
    .out_ie    (out_ie),
    .irq       (irq)
  );
endmodule

// File: rtl/avg_accum_chk.sv
module avg_accum_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned CTL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTL_W-1:0]  avg_ctl,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [TAG_W-1:0]  out_tag,
  input logic              out_ie,
  input logic              irq,
  input logic              grp_idle
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_ie))); // R8

  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (avg_ctl == '0) && grp_idle) |=> (out_valid && (out_data == $past(in_data)))); // R2

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_valid && in_ready) && !$past(out_valid)) |-> !out_valid); // R3

  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(out_ie) && $past(out_ready))); // R9

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_valid) |-> !irq); // R9
endmodule

bind avg_accum avg_accum_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W), .CTL_W(CTL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .avg_ctl   (avg_ctl),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_tag   (out_tag),
  .out_ie    (out_ie),
  .irq       (irq),
  .grp_idle  (grp_idle)
);

// File: tb/avg_accum_bench.sv
`timescale 1ns/1ps
module avg_accum_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  avg_ctl = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic [3:0]  in_tag = '0;
  logic        in_ie = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_data;
  logic [3:0]  out_tag;
  logic        out_ie;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int rdy_mode = 0;
  int irq_cnt = 0;
  bit cmp_on = 0;
  bit finished = 0;
  int got_q[$];

  // reference model state
  bit m_ov, m_irq, m_oie, m_tk;
  int m_od, m_ot, m_cnt, m_sum, m_log;

  always #5 clk = ~clk;

  avg_accum u_avg_accum (
    .clk(clk), .rst_n(rst_n), .avg_ctl(avg_ctl),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_tag(in_tag), .in_ie(in_ie),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .out_ie(out_ie), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ov = 0; m_irq = 0; m_oie = 0; m_od = 0; m_ot = 0;
      m_cnt = 0; m_sum = 0; m_log = 0;
    end else begin
      m_irq = m_ov && out_ready && m_oie;
      m_tk  = in_valid && (!m_ov || out_ready);
      if (m_ov && out_ready) m_ov = 0;
      if (m_tk) begin
        if (m_cnt == 0) begin
          m_log = (int'(avg_ctl) > 6) ? 6 : int'(avg_ctl);
          m_sum = 0;
        end
        m_sum = m_sum + int'(in_data);
        m_cnt = m_cnt + 1;
        if (m_cnt == (1 << m_log)) begin
          m_od = m_sum >> m_log; m_ot = int'(in_tag); m_oie = in_ie;
          m_ov = 1; m_cnt = 0;
        end
      end
    end
  end

  // compare and capture away from the rising edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R3 out_valid", int'(out_valid), int'(m_ov));
      check("R8 in_ready", int'(in_ready), int'(!m_ov || out_ready));
      check("R9 irq", int'(irq), int'(m_irq));
      if (m_ov) begin
        check("R3 out_data", int'(out_data), m_od);
        check("R6 out_tag", int'(out_tag), m_ot);
        check("R6 out_ie", int'(out_ie), int'(m_oie));
      end
      if (out_valid && out_ready)
        got_q.push_back((int'(out_data) << 5) | (int'(out_tag) << 1) | int'(out_ie));
      if (irq) irq_cnt++;
    end
  end

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  task automatic send(int d, int t, bit ie);
    in_valid = 1'b1; in_data = 12'(d); in_tag = 4'(t); in_ie = ie;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic expect_entry(string req, int d, int t, bit ie);
    int e;
    if (got_q.size() == 0) begin
      check({req, " entry count"}, 0, 1);
    end else begin
      e = got_q.pop_front();
      check({req, " data"}, e >> 5, d);
      check({req, " tag"}, (e >> 1) & 15, t);
      check({req, " ie"}, e & 1, int'(ie));
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 irq in reset", int'(irq), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #2;

    // R2 bypass
    got_q.delete();
    send(12'hABC, 3, 0);
    send(12'h005, 7, 0);
    settle();
    expect_entry("R2 bypass first", 12'hABC, 3, 0);
    expect_entry("R2 bypass second", 12'h005, 7, 0);

    // R3 four-sample group, R6 tag from last
    avg_ctl = 3'd2;
    got_q.delete();
    send(10, 1, 0); send(20, 2, 0); send(30, 3, 0);
    settle();
    check("R3 no entry before group end", got_q.size(), 0);
    send(41, 5, 1);
    settle();
    expect_entry("R3 R6 group of four", 25, 5, 1);

    // R3 truncation
    avg_ctl = 3'd1;
    got_q.delete();
    send(1, 0, 0); send(2, 0, 0);
    settle();
    expect_entry("R3 truncation", 1, 0, 0);

    // R10 mixed tags averaged together
    got_q.delete();
    send(4000, 0, 0); send(1000, 9, 0);
    settle();
    expect_entry("R10 mixed tags", 2500, 9, 0);

    // R4 R7 control 7 acts as 64 samples, full scale
    avg_ctl = 3'd7;
    got_q.delete();
    for (int i = 0; i < 63; i++) send(4095, 2, 0);
    settle();
    check("R4 no entry after 63", got_q.size(), 0);
    send(4095, 4, 0);
    settle();
    expect_entry("R7 full scale 64", 4095, 4, 0);
    for (int i = 0; i < 64; i++) send(i, 6, 0);
    settle();
    expect_entry("R4 ramp 64", 31, 6, 0);

    // R5 mid-group change deferred
    avg_ctl = 3'd1;
    got_q.delete();
    send(100, 1, 0);
    avg_ctl = 3'd0;
    settle();
    check("R5 no early close", got_q.size(), 0);
    send(201, 2, 0);
    settle();
    expect_entry("R5 old factor kept", 150, 2, 0);
    send(7, 3, 0);
    settle();
    expect_entry("R5 new factor applies", 7, 3, 0);

    // R9 interrupt
    irq_cnt = 0;
    send(9, 1, 1);
    settle();
    check("R9 flagged bypass pulse", irq_cnt, 1);
    send(9, 1, 0);
    settle();
    check("R9 unflagged no pulse", irq_cnt, 1);
    avg_ctl = 3'd2;
    send(1, 0, 1); send(1, 0, 0); send(1, 0, 0); send(1, 0, 0);
    settle();
    check("R9 R6 flag on first sample only", irq_cnt, 1);
    send(1, 0, 0); send(1, 0, 0); send(1, 0, 0); send(1, 0, 1);
    settle();
    check("R9 R6 flag on last sample", irq_cnt, 2);

    // R8 back-pressure
    avg_ctl = 3'd0;
    got_q.delete();
    rdy_mode = 2;
    settle();
    send(12'h123, 8, 0);
    in_valid = 1'b1; in_data = 12'h456; in_tag = 4'd9; in_ie = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 held valid", int'(out_valid), 1);
    check("R8 in_ready low", int'(in_ready), 0);
    check("R8 held data", int'(out_data), 12'h123);
    @(posedge clk); #2;
    rdy_mode = 0;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
    settle();
    expect_entry("R8 held entry", 12'h123, 8, 0);
    expect_entry("R8 waiting sample", 12'h456, 9, 0);

    // random phase against the model
    rdy_mode = 1;
    for (int i = 0; i < 500; i++) begin
      if ((i % 37) == 0) avg_ctl = 3'($urandom);
      send(int'($urandom % 4096), int'($urandom % 16), 1'($urandom));
      if (($urandom % 4) == 0) begin @(posedge clk); #2; end
    end
    rdy_mode = 0;
    settle();

    finished = 1;
    summary();
    $finish;
  end
endmodule